// File: doc/BRIEF.md
# ROM Signature Self-Test Controller

This block tests a read-only memory on its own. It reads every word, starting at address zero and counting upward, and folds each word into a signature register. That register is a shift register whose low-end bit feeds back through XOR taps chosen by a polynomial parameter. When a sweep ends, the accumulated signature is compared with a golden value supplied on an input port. Computing the golden value is left to whoever programs the memory.

The block makes two complete sweeps of the memory. Between them it stops in a self-pause and waits for an external release. A read that disturbs the stored contents therefore produces a wrong signature on the second sweep. The signature register is reloaded from the seed input at the start of each sweep, so a memory that is read back faithfully gives the same signature on both sweeps.

The memory is assumed to return data one cycle after the address and enable are presented. The controller captures a word only in the cycle in which that data is valid.

Top module: `rom_sig_bist`

## Requirements
- R1: While and after reset, and before any start, `busy_o`, `paused_o`, `done_o`, `fail_o`, `pass_o` and `rom_en_o` are 0 and `sig_o` is 0.
- R2: Each sweep holds `rom_en_o` high for exactly 2^ADDR_W consecutive cycles. It presents addresses 0, 1, 2 … 2^ADDR_W−1, one per cycle in ascending order. Two sweeps give 2·2^ADDR_W reads in total.
- R3: The signature is loaded from `seed_i` at the start of each sweep. For each returned word d, the next state is `{1'b0, s[W-1:1]} ^ (s[0] ? POLY : 0) ^ d`. After each sweep, `sig_o` equals this fold over all words in address order.
- R4: At the end of each sweep, `sig_o` is compared with `golden_i`, and a mismatch sets `fail_o`. `fail_o` stays set until the next accepted start. `pass_o` equals `done_o & ~fail_o`.
- R5: After the first sweep, `paused_o` is high and no read is issued until `resume_i` is high. A `resume_i` given outside the pause has no effect. If `resume_i` is already high when the pause begins, the pause lasts exactly one cycle.
- R6: `done_o` rises after the second comparison, with `busy_o` low. It stays high until a new start. A `start_i` given while `busy_o` is high is ignored.
- R7: A word that differs between the two sweeps (a read-disturb fault) leaves `fail_o` clear at the pause but set at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a test when idle or done |
| resume_i | input | 1 | Releases the self-pause |
| seed_i | input | DATA_W | Signature starting value |
| golden_i | input | DATA_W | Expected signature |
| rom_addr_o | output | ADDR_W | Memory address |
| rom_en_o | output | 1 | Memory read enable |
| rom_data_i | input | DATA_W | Memory read data, one cycle after enable |
| busy_o | output | 1 | Test in progress, including the pause |
| paused_o | output | 1 | Self-pause between sweeps |
| done_o | output | 1 | Both sweeps compared |
| pass_o | output | 1 | Done with no mismatch |
| fail_o | output | 1 | A sweep signature mismatched |
| sig_o | output | DATA_W | Current signature |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the self-pause and its release. The bench holds `resume_i` high from before the start, so the release is already present in the first cycle of the pause. The check is that the pause lasts exactly one cycle and the second sweep still starts cleanly at address 0. The second pair is a start pulse and an ongoing sweep: `start_i` is pulsed while reads are in flight, and the unbroken ascending address trace and unchanged signatures show that the pulse was ignored.

// File: rtl/rbist_pkg.sv
package rbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_TAIL,
        ST_CMP,
        ST_PAUSE,
        ST_DONE
    } rbist_state_t;

    typedef struct packed {
        logic load;     // reseed signature, rewind address
        logic read;     // issue one memory read
        logic compare;  // judge signature against golden
    } rbist_ctl_t;

    function automatic logic is_active(rbist_state_t s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

endpackage

// File: rtl/rbist_addr_gen.sv
module rbist_addr_gen #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)        addr <= '0;
        else if (clear) addr <= '0;
        else if (step)  addr <= addr + 1'b1;
    end

    assign last = (addr == TOP_ADDR);

    // R2: back-to-back reads walk up by exactly one
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        step |=> (!step || ((addr - $past(addr)) == ADDR_W'(1))));

endmodule

// File: rtl/rbist_misr.sv
module rbist_misr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    POLY = 16'hB400
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         cap,
    input  logic [W-1:0] data,
    output logic [W-1:0] sig
);
    logic [W-1:0] state_q;
    logic [W-1:0] fold;

    always_comb begin
        fold = {1'b0, state_q[W-1:1]} ^ data;
        if (state_q[0]) fold = fold ^ POLY;
    end

    always_ff @(posedge clk) begin
        if (rst)       state_q <= '0;
        else if (load) state_q <= seed;
        else if (cap)  state_q <= fold;
    end

    assign sig = state_q;

    // R3: reseed takes the seed value
    p_seed_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (state_q == $past(seed)));

    // R3: without capture or load the signature holds
    p_sig_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !cap) |=> $stable(state_q));

endmodule

// File: rtl/rbist_ctrl.sv
module rbist_ctrl
    import rbist_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       resume,
    input  logic       last,
    input  logic       match,
    output rbist_ctl_t ctl,
    output logic       busy,
    output logic       paused,
    output logic       done,
    output logic       fail
);
    rbist_state_t state_q, state_d;
    logic         second_q;
    logic         fail_q;
    logic         accept;

    assign accept = start && !is_active(state_q);

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) state_d = ST_LOAD;
            ST_LOAD: begin
                ctl.load = 1'b1;
                state_d  = ST_RUN;
            end
            ST_RUN: begin
                ctl.read = 1'b1;
                if (last) state_d = ST_TAIL;
            end
            ST_TAIL: state_d = ST_CMP;
            ST_CMP: begin
                ctl.compare = 1'b1;
                state_d     = second_q ? ST_DONE : ST_PAUSE;
            end
            ST_PAUSE: if (resume) state_d = ST_LOAD;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            second_q <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                second_q <= 1'b0;
                fail_q   <= 1'b0;
            end else begin
                if (state_q == ST_PAUSE && resume) second_q <= 1'b1;
                if (ctl.compare && !match)          fail_q   <= 1'b1;
            end
        end
    end

    assign busy   = is_active(state_q);
    assign paused = (state_q == ST_PAUSE);
    assign done   = (state_q == ST_DONE);
    assign fail   = fail_q;

    // R5: no reads during the pause
    p_pause_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        paused |-> !ctl.read);

    // R6: done means idle with no reads
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !ctl.read));

    // R4: a mismatch flag persists through the rest of the test
    p_fail_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (fail && busy) |=> fail);

    // R5: the pause is left only toward a reseed
    p_pause_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (paused && resume) |=> ctl.load);

endmodule

// File: rtl/rom_sig_bist.sv
module rom_sig_bist
    import rbist_pkg::*;
#(
    parameter int                 ADDR_W = 6,
    parameter int                 DATA_W = 16,
    parameter logic [DATA_W-1:0]  POLY   = 16'hB400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              resume_i,
    input  logic [DATA_W-1:0] seed_i,
    input  logic [DATA_W-1:0] golden_i,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              rom_en_o,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic              busy_o,
    output logic              paused_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [DATA_W-1:0] sig_o
);
    rbist_ctl_t        ctl;
    logic              last;
    logic              cap_q;
    logic [DATA_W-1:0] sig;

    rbist_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .resume (resume_i),
        .last   (last),
        .match  (sig == golden_i),
        .ctl    (ctl),
        .busy   (busy_o),
        .paused (paused_o),
        .done   (done_o),
        .fail   (fail_o)
    );

    rbist_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.load),
        .step  (ctl.read),
        .addr  (rom_addr_o),
        .last  (last)
    );

    // data is valid one cycle after the enable
    always_ff @(posedge clk) begin
        if (rst) cap_q <= 1'b0;
        else     cap_q <= ctl.read;
    end

    rbist_misr #(.W(DATA_W), .POLY(POLY)) u_misr (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.load),
        .seed (seed_i),
        .cap  (cap_q),
        .data (rom_data_i),
        .sig  (sig)
    );

    assign rom_en_o = ctl.read;
    assign sig_o    = sig;
    assign pass_o   = done_o && !fail_o;

    // R3: every capture follows a read one cycle earlier
    p_cap_after_read_r3: assert property (@(posedge clk) disable iff (rst)
        cap_q |-> $past(rom_en_o));

endmodule

// File: tb/rom_sig_bist_test.sv
`timescale 1ns/1ps
module rom_sig_bist_test;
    localparam int          AW    = 6;
    localparam int          DW    = 16;
    localparam int          DEPTH = 1 << AW;
    localparam logic [DW-1:0] POLY = 16'hB400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, resume_i = 1'b0;
    logic [DW-1:0] seed_i = '0, golden_i = '0;
    logic [AW-1:0] rom_addr_o;
    logic rom_en_o;
    logic [DW-1:0] rom_q = '0;
    logic busy_o, paused_o, done_o, pass_o, fail_o;
    logic [DW-1:0] sig_o;

    always #2 clk = ~clk;

    rom_sig_bist #(.ADDR_W(AW), .DATA_W(DW), .POLY(POLY)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .resume_i(resume_i),
        .seed_i(seed_i), .golden_i(golden_i), .rom_addr_o(rom_addr_o),
        .rom_en_o(rom_en_o), .rom_data_i(rom_q), .busy_o(busy_o),
        .paused_o(paused_o), .done_o(done_o), .pass_o(pass_o),
        .fail_o(fail_o), .sig_o(sig_o)
    );

    logic [DW-1:0] mem [DEPTH];
    bit corrupt = 0, second = 0;
    int checks = 0, failures = 0;
    int rd_cnt = 0, addr_err = 0, pause_cnt = 0, exp_addr = 0;
    bit finished = 0;

    // memory model, one-cycle latency, optional read-disturb on sweep two
    always @(posedge clk)
        if (rom_en_o) rom_q <= mem[rom_addr_o] ^ ((corrupt && second) ? 16'h0001 : 16'h0000);

    // address trace monitor (R2)
    always @(negedge clk) begin
        if (!rst) begin
            if (rom_en_o) begin
                if (exp_addr >= DEPTH || rom_addr_o != AW'(exp_addr)) addr_err++;
                exp_addr++;
                rd_cnt++;
            end else if (exp_addr != 0 && exp_addr != DEPTH) begin
                addr_err++;
                exp_addr = DEPTH;
            end
            if (paused_o) pause_cnt++;
            if (paused_o || !busy_o) exp_addr = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] calc(input logic [DW-1:0] s0, input bit flip);
        logic [DW-1:0] s = s0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [DW-1:0] d = mem[i] ^ (flip ? 16'h0001 : 16'h0000);
            s = (s >> 1) ^ (s[0] ? POLY : '0) ^ d;
        end
        return s;
    endfunction

    task automatic wait_paused();
        int n = 0;
        while (!paused_o && n < 2000) begin @(negedge clk); n++; end
        chk(paused_o, "R5", "pause reached", 32'(paused_o), 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 2000) begin @(negedge clk); n++; end
        chk(done_o, "R6", "done reached", 32'(done_o), 1);
    endtask

    task automatic run(input bit bad, input bit corr, input bit hold_rel, input bit poke);
        logic [DW-1:0] e1, e2;
        int base_rd, base_pc, base_ae;
        bit expfail;
        corrupt = corr; second = 0;
        e1 = calc(seed_i, 0);
        e2 = calc(seed_i, corr && !hold_rel);
        golden_i = bad ? (e1 ^ 16'h0001) : e1;
        expfail = bad || (corr && !hold_rel);
        base_rd = rd_cnt; base_pc = pause_cnt; base_ae = addr_err;
        resume_i = hold_rel;
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        chk(busy_o && !done_o, "R6", "busy after start", 32'(busy_o), 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            start_i = 1; @(negedge clk); start_i = 0;   // R6: ignored while busy
            if (!hold_rel) begin
                repeat (5) @(negedge clk);
                resume_i = 1; @(negedge clk); resume_i = 0; // R5: ignored mid-sweep
            end
        end
        if (!hold_rel) begin
            wait_paused();
            chk(sig_o == e1, "R3", "sweep-1 signature", 32'(sig_o), 32'(e1));
            chk(rd_cnt - base_rd == DEPTH, "R2", "sweep-1 reads", rd_cnt - base_rd, DEPTH);
            chk(fail_o == bad, "R4", "fail at pause", 32'(fail_o), 32'(bad));
            if (corr) chk(!fail_o, "R7", "no fail before disturb shows", 32'(fail_o), 0);
            repeat (4) @(negedge clk);
            chk(paused_o && rd_cnt - base_rd == DEPTH, "R5", "pause holds without release",
                rd_cnt - base_rd, DEPTH);
            second = 1;
            resume_i = 1; @(negedge clk); resume_i = 0;
        end
        wait_done();
        chk(sig_o == e2, "R3", "sweep-2 signature", 32'(sig_o), 32'(e2));
        chk(rd_cnt - base_rd == 2 * DEPTH, "R2", "total reads", rd_cnt - base_rd, 2 * DEPTH);
        chk(addr_err == base_ae, "R2", "ascending address trace", addr_err - base_ae, 0);
        chk(fail_o == expfail, corr ? "R7" : "R4", "fail at done", 32'(fail_o), 32'(expfail));
        chk(pass_o == !expfail && !busy_o, "R4", "pass flag", 32'(pass_o), 32'(!expfail));
        if (hold_rel)
            chk(pause_cnt - base_pc == 1, "R5", "one-cycle pause", pause_cnt - base_pc, 1);
        repeat (3) @(negedge clk);
        chk(done_o && !busy_o, "R6", "done held", 32'(done_o), 1);
        resume_i = 0; second = 0;
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED);
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'($urandom);
        repeat (3) @(negedge clk);
        chk(!busy_o && !paused_o && !done_o && !fail_o && !pass_o && !rom_en_o && sig_o == 0,
            "R1", "state in reset", {busy_o, paused_o, done_o, fail_o, pass_o, rom_en_o}, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !rom_en_o && !done_o && sig_o == 0, "R1", "idle after reset",
            {busy_o, rom_en_o, done_o}, 0);
        for (int k = 0; k < 3; k++) begin
            seed_i = 16'($urandom);
            run(0, 0, 0, 0);
        end
        run(1, 0, 0, 0);               // wrong golden
        seed_i = 16'($urandom);
        run(0, 1, 0, 0);               // read disturb (R7)
        run(0, 0, 1, 1);               // release pre-held, start poked while busy
        run(0, 0, 0, 1);               // stray start and release mid-sweep
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        seed_i = '0;
        run(0, 0, 0, 0);               // all-zero corner
        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
        seed_i = '1;
        run(0, 0, 0, 0);               // all-ones corner
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule